// File: doc/BRIEF.md
# Strap-Addressed SMBus Configuration Register Slave

This block is a synchronous two-wire slave that lets a host reach a small bank of 8-bit configuration registers. The system clock samples SCL and SDA. Both lines pass through a two-flop synchronizer and a glitch filter. The block then detects START and STOP, and it declares the bus idle after a timed interval with both lines high. The slave drives SDA only through an open-drain enable. The contents of the register bank are always visible on a parallel output bus.

The 7-bit device address is a fixed base pattern plus the value on four strap pins. A host writes a register with three bytes: the address byte, a register index and a data byte. A host reads a register by writing the index, issuing a repeated START and then sending the address byte with the read bit set. The slave returns the selected register most significant bit first. The last register of the bank is read-only and holds a fixed value.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The device address is 7'h58 plus the strap value, so the write address byte is 0xB0 + 2*strap (0xB0..0xCE). Bit 0 of the address byte selects the direction: 0 is write and 1 is read. A matching address byte is acknowledged.
- R2: If the address byte does not match, the slave does not acknowledge it. The slave then leaves SDA alone for every later byte until the next START.
- R3: A write is START, address byte (write), register index, data byte, STOP. The slave acknowledges each of the three bytes, and the data byte appears on the matching 8-bit lane of regs_o (lane i is bits 8*i+7..8*i).
- R4: A register write takes effect at the acknowledge of the data byte. A write to the read-only register (index NUM_REGS-1, fixed at 0x5A) changes nothing. A write to an index of NUM_REGS or more changes nothing, although all three bytes are still acknowledged.
- R5: A read is a write of the index, a repeated START, and the address byte with bit 0 set. The slave shifts out the indexed register MSB first. An index of NUM_REGS or more reads as 0x00.
- R6: To acknowledge, the slave pulls SDA low for the whole of the ninth clock of a byte. The slave changes its SDA drive only while SCL is low.
- R7: A STOP (SDA rising while SCL is high) ends the transaction and releases the bus. A START (SDA falling while SCL is high) at any point, including in the middle of a write, restarts the address phase and discards the unfinished write.
- R8: After a STOP, bus_idle_o rises once both lines have stayed high for T_BUF system clocks (64 by default). bus_idle_o clears on the next START.
- R9: If both lines stay high for T_HIGH_MAX system clocks (512 by default), bus_idle_o rises even without a STOP. This aborts any transaction in progress, and a partly received data byte is discarded.
- R10: A pulse on SCL that lasts fewer than FILT_LEN system clocks (3 by default) is ignored and does not count as a bit.
- R11: After reset, every writable register is 0x00, the read-only register is 0x5A, sda_oe_o is low and bus_idle_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 4 | Address strap value added to the base address |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| bus_idle_o | output | 1 | Bus has reached the idle condition |
| regs_o | output | 64 | Register bank, lane i on bits 8*i+7..8*i |

## Verification
The bench checks the acknowledge bit of every byte. A slave that decodes the strap pins wrongly would acknowledge a foreign address or ignore its own, and one that does not step off the bus after a mismatch would pull SDA low during later acknowledge slots. The read-only register, an out-of-range index, a repeated START in place of the data byte and a host stalled with both lines high each probe whether the commit point is right: a slave that commits too early or ignores the abort would change a register that must stay put. A two-clock SCL glitch in the middle of a byte would shift the bit count and corrupt the written value if the filter were missing. The bench also times bus_idle_o against the bus-free and maximum-high limits.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_ADDR,
    S_REG,
    S_ACK_REG,
    S_DATA,
    S_ACK_DATA,
    S_READ,
    S_READ_ACK,
    S_SKIP
  } smb_state_t;
endpackage

// File: rtl/cfg_smb_filt.sv
module cfg_smb_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == clean_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        clean_o <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_o != $past(clean_o)) |-> ($past(sync_q[1]) == clean_o)); // R10
endmodule

// File: rtl/cfg_smb_cond.sv
module cfg_smb_cond #(
  parameter int T_BUF      = 64,
  parameter int T_HIGH_MAX = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic idle_o
);
  localparam int CNT_MAX = (T_HIGH_MAX > T_BUF) ? T_HIGH_MAX : T_BUF;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             scl_q, sda_q, stop_seen_q;
  logic [CNT_W-1:0] hi_cnt_q;

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      stop_seen_q <= 1'b0;
      hi_cnt_q    <= '0;
      idle_o      <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (!(scl_i && sda_i))                hi_cnt_q <= '0;
      else if (hi_cnt_q != CNT_W'(CNT_MAX)) hi_cnt_q <= hi_cnt_q + 1'b1;
      if (start_o) begin
        stop_seen_q <= 1'b0;
        idle_o      <= 1'b0;
      end else begin
        if (stop_o) stop_seen_q <= 1'b1;
        if ((stop_seen_q && hi_cnt_q >= CNT_W'(T_BUF)) || hi_cnt_q >= CNT_W'(T_HIGH_MAX))
          idle_o <= 1'b1;
      end
    end
  end

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> ($past(scl_i) && $past(sda_i))); // R8
  AST_START_CLEARS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !idle_o); // R8
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfg_smb_pkg::*;
#(
  parameter int                  NUM_REGS   = 8,
  parameter int                  STRAP_W    = 4,
  parameter int                  FILT_LEN   = 3,
  parameter int                  T_BUF      = 64,
  parameter int                  T_HIGH_MAX = 512,
  parameter logic [6:0]          ADDR_BASE  = 7'h58,
  parameter logic [NUM_REGS-1:0] RO_MASK    = NUM_REGS'(1) << (NUM_REGS - 1),
  parameter logic [BYTE_W-1:0]   RO_VAL     = 8'h5A
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         scl_i,
  input  logic                         sda_i,
  input  logic [STRAP_W-1:0]           strap_i,
  output logic                         sda_oe_o,
  output logic                         bus_idle_o,
  output logic [NUM_REGS*BYTE_W-1:0]   regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [1:0] raw_lines, clean_lines;
  logic       scl_c, sda_c;
  logic       start, stop, scl_rise, scl_fall;

  assign raw_lines = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    cfg_smb_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_lines[l]),
      .clean_o(clean_lines[l])
    );
  end

  assign scl_c = clean_lines[1];
  assign sda_c = clean_lines[0];

  cfg_smb_cond #(.T_BUF(T_BUF), .T_HIGH_MAX(T_HIGH_MAX)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_c),
    .sda_i     (sda_c),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .idle_o    (bus_idle_o)
  );

  smb_state_t        state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, ptr_q;
  logic              rd_mode_q;
  logic [6:0]        dev_addr;
  logic              ptr_ok, byte_done, commit;
  logic [BYTE_W-1:0] rd_val;
  logic [BYTE_W-1:0] reg_val [NUM_REGS];
  logic [NUM_REGS-1:0] wr_en;

  assign dev_addr  = ADDR_BASE + 7'(strap_i);
  assign ptr_ok    = int'(ptr_q) < NUM_REGS;
  assign byte_done = scl_fall && bit_cnt_q == 4'd8;
  assign commit    = state_q == S_DATA && byte_done && !start && !stop && !bus_idle_o;
  assign rd_val    = ptr_ok ? reg_val[ptr_q[IDX_W-1:0]] : '0;

  always_comb begin
    wr_en = '0;
    if (commit && ptr_ok) wr_en[ptr_q[IDX_W-1:0]] = 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (RO_MASK[i]) begin : g_ro
      assign reg_val[i] = RO_VAL;
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       reg_val[i] <= '0;
        else if (wr_en[i]) reg_val[i] <= shreg_q;
      end
      AST_COMMIT_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_val[i] != $past(reg_val[i])) |-> ($past(state_q) == S_DATA)); // R4
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = reg_val[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rd_mode_q <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (start) begin
      state_q   <= S_ADDR;
      bit_cnt_q <= '0;
      sda_oe_o  <= 1'b0;
    end else if (stop || bus_idle_o) begin
      state_q  <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_REG, S_DATA: begin
          if (scl_rise) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_c};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            if (state_q == S_ADDR) begin
              if (shreg_q[7:1] == dev_addr) begin
                sda_oe_o  <= 1'b1;
                rd_mode_q <= shreg_q[0];
                state_q   <= S_ACK_ADDR;
              end else begin
                state_q <= S_SKIP;
              end
            end else if (state_q == S_REG) begin
              ptr_q    <= shreg_q;
              sda_oe_o <= 1'b1;
              state_q  <= S_ACK_REG;
            end else begin
              sda_oe_o <= 1'b1;
              state_q  <= S_ACK_DATA;
            end
          end
        end
        S_ACK_ADDR: if (scl_fall) begin
          if (rd_mode_q) begin
            sda_oe_o <= ~rd_val[7];
            tx_q     <= {rd_val[6:0], 1'b0};
            state_q  <= S_READ;
          end else begin
            sda_oe_o <= 1'b0;
            state_q  <= S_REG;
          end
        end
        S_ACK_REG: if (scl_fall) begin
          sda_oe_o <= 1'b0;
          state_q  <= S_DATA;
        end
        S_ACK_DATA: if (scl_fall) begin
          sda_oe_o <= 1'b0;
          state_q  <= S_SKIP;
        end
        S_READ: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            sda_oe_o  <= 1'b0;
            state_q   <= S_READ_ACK;
          end else if (scl_fall) begin
            sda_oe_o <= ~tx_q[7];
            tx_q     <= {tx_q[6:0], 1'b0};
          end
        end
        S_READ_ACK: if (scl_fall) state_q <= S_SKIP;
        default: ;
      endcase
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_c); // R6
  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SKIP) |-> !sda_oe_o); // R2
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_o && !start) |=> (state_q == S_IDLE && !sda_oe_o)); // R9
  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == S_ADDR)); // R7
endmodule

// File: tb/cfg_smbus_slave_test.sv
module cfg_smbus_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_host = 1'b1;
  logic [3:0]  strap = 4'd0;
  logic        sda_oe;
  logic        bus_idle;
  logic [63:0] regs;
  logic        sda_line;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   cmp_en = 1'b0;
  logic [7:0] exp_regs [8];

  always #5 clk = ~clk;

  assign sda_line = sda_host & ~sda_oe;

  cfg_smbus_slave uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_oe_o  (sda_oe),
    .bus_idle_o(bus_idle),
    .regs_o    (regs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference register bank compared on every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < 8; i++) check("R3/R4 bank", regs[i*8 +: 8], exp_regs[i]);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic bus_start();
    sda_host = 1'b0; tick(20);
    scl = 1'b0;      tick(10);
  endtask

  task automatic bus_restart();
    sda_host = 1'b1; tick(10);
    scl = 1'b1;      tick(20);
    sda_host = 1'b0; tick(20);
    scl = 1'b0;      tick(10);
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; tick(10);
    scl = 1'b1;      tick(20);
    sda_host = 1'b1; tick(20);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_host = b;
    if (glitch) begin
      tick(3); scl = 1'b1; tick(2); scl = 1'b0; tick(5);
    end else begin
      tick(10);
    end
    scl = 1'b1; tick(20);
    scl = 1'b0; tick(10);
  endtask

  task automatic get_bit(output logic b);
    sda_host = 1'b1; tick(10);
    scl = 1'b1;      tick(10);
    b = sda_line;    tick(10);
    scl = 1'b0;      tick(10);
  endtask

  task automatic send_byte(input logic [7:0] v, input int glitch_bit, output logic ack);
    for (int k = 7; k >= 0; k--) put_bit(v[k], k == glitch_bit);
    get_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b);
      v[k] = b;
    end
    put_bit(1'b1, 1'b0); // host NACK
  endtask

  function automatic logic [7:0] addr_byte(input logic [3:0] s, input logic rd);
    return {7'h58 + 7'(s), rd};
  endfunction

  task automatic write_reg(input logic [3:0] s, input logic [7:0] idx, input logic [7:0] v,
                           input int glitch_bit, input string req, input logic exp_ack);
    logic a;
    cmp_en = 1'b0;
    bus_start();
    send_byte(addr_byte(s, 1'b0), -1, a);      check({req, " addr ack"}, 8'(a), 8'(!exp_ack));
    send_byte(idx, glitch_bit, a);             check({req, " index ack"}, 8'(a), 8'(!exp_ack));
    send_byte(v, -1, a);                       check({req, " data ack"}, 8'(a), 8'(!exp_ack));
    bus_stop();
    if (exp_ack && idx < 8 && idx != 7) exp_regs[idx[2:0]] = v;
    cmp_en = 1'b1;
  endtask

  task automatic read_reg(input logic [3:0] s, input logic [7:0] idx, output logic [7:0] v);
    logic a;
    cmp_en = 1'b0;
    bus_start();
    send_byte(addr_byte(s, 1'b0), -1, a); check("R5 addr ack", 8'(a), 8'h00);
    send_byte(idx, -1, a);                check("R5 index ack", 8'(a), 8'h00);
    bus_restart();
    send_byte(addr_byte(s, 1'b1), -1, a); check("R5 read addr ack", 8'(a), 8'h00);
    recv_byte(v);
    bus_stop();
    cmp_en = 1'b1;
  endtask

  initial begin
    logic [7:0] rv;
    logic       a;
    for (int i = 0; i < 8; i++) exp_regs[i] = (i == 7) ? 8'h5A : 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R11 reset state
    for (int i = 0; i < 8; i++) check("R11 reset reg", regs[i*8 +: 8], exp_regs[i]);
    check("R11 reset oe", 8'(sda_oe), 8'h00);
    check("R11 reset idle", 8'(bus_idle), 8'h00);
    cmp_en = 1'b1;

    // R9 max-high timeout without a STOP
    tick(300); check("R9 idle before high limit", 8'(bus_idle), 8'h00);
    tick(300); check("R9 idle after high limit", 8'(bus_idle), 8'h01);

    // R1 R3 R6 basic write at strap 0 (address byte 0xB0)
    check("R1 address byte strap 0", addr_byte(4'd0, 1'b0), 8'hB0);
    write_reg(4'd0, 8'd1, 8'h3C, -1, "R3 write", 1'b1);
    check("R8 idle clear after start", 8'(bus_idle), 8'h00);
    tick(30);  check("R8 idle before bus-free", 8'(bus_idle), 8'h00);
    tick(70);  check("R8 idle after bus-free", 8'(bus_idle), 8'h01);

    // R1 another strap value
    strap = 4'd9;
    write_reg(4'd9, 8'd4, 8'hA7, -1, "R1 strap 9", 1'b1);
    strap = 4'd15;
    check("R1 address byte strap 15", addr_byte(4'd15, 1'b0), 8'hCE);
    write_reg(4'd15, 8'd0, 8'hF1, -1, "R1 strap 15", 1'b1);

    // R2 foreign address: no ack, slave stays off the bus
    strap = 4'd3;
    write_reg(4'd5, 8'd2, 8'hEE, -1, "R2 mismatch", 1'b0);
    check("R2 reg2 untouched", regs[2*8 +: 8], 8'h00);

    // R4 read-only and out-of-range writes
    write_reg(4'd3, 8'd7, 8'h11, -1, "R4 ro write", 1'b1);
    check("R4 ro reg value", regs[7*8 +: 8], 8'h5A);
    write_reg(4'd3, 8'd200, 8'h99, -1, "R4 range write", 1'b1);

    // R5 reads
    read_reg(4'd3, 8'd4, rv);   check("R5 read reg4", rv, 8'hA7);
    read_reg(4'd3, 8'd1, rv);   check("R5 read reg1", rv, 8'h3C);
    read_reg(4'd3, 8'd7, rv);   check("R5 read ro reg", rv, 8'h5A);
    read_reg(4'd3, 8'd200, rv); check("R5 read out of range", rv, 8'h00);

    // R7 repeated START in place of the data byte discards the write
    cmp_en = 1'b0;
    bus_start();
    send_byte(addr_byte(4'd3, 1'b0), -1, a); check("R7 addr ack", 8'(a), 8'h00);
    send_byte(8'd2, -1, a);                  check("R7 index ack", 8'(a), 8'h00);
    bus_restart();
    send_byte(addr_byte(4'd3, 1'b0), -1, a); check("R7 restart addr ack", 8'(a), 8'h00);
    send_byte(8'd3, -1, a);                  check("R7 restart index ack", 8'(a), 8'h00);
    send_byte(8'h66, -1, a);                 check("R7 restart data ack", 8'(a), 8'h00);
    bus_stop();
    exp_regs[3] = 8'h66;
    cmp_en = 1'b1;
    check("R7 reg2 kept", regs[2*8 +: 8], 8'h00);
    check("R7 reg3 written", regs[3*8 +: 8], 8'h66);

    // R10 two-clock SCL glitch inside the index byte
    write_reg(4'd3, 8'd5, 8'h81, 4, "R10 glitch", 1'b1);
    check("R10 reg5", regs[5*8 +: 8], 8'h81);

    // R9 host stalls mid data byte with both lines high
    cmp_en = 1'b0;
    bus_start();
    send_byte(addr_byte(4'd3, 1'b0), -1, a); check("R9 addr ack", 8'(a), 8'h00);
    send_byte(8'd6, -1, a);                  check("R9 index ack", 8'(a), 8'h00);
    for (int k = 0; k < 3; k++) put_bit(1'b1, 1'b0);
    sda_host = 1'b1; tick(10);
    scl = 1'b1; tick(700);
    check("R9 stall idle", 8'(bus_idle), 8'h01);
    check("R9 stall oe", 8'(sda_oe), 8'h00);
    check("R9 reg6 untouched", regs[6*8 +: 8], 8'h00);
    cmp_en = 1'b1;
    write_reg(4'd3, 8'd6, 8'h42, -1, "R9 after abort", 1'b1);
    check("R9 reg6 later write", regs[6*8 +: 8], 8'h42);

    tick(20);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule